// File: doc/BRIEF.md
# Channel Switch Register Bank

This block holds the registers of an eight-channel bus switch that sits behind a byte-oriented serial slave front end. The front end hands it decoded events: a transaction start, a written byte with a strobe and a flag that says whether all eight bits arrived, a read request, and a stop. There is no register-address phase. Every transaction begins at index 0, and an internal pointer moves one step for each byte transferred.

Writes can reach the channel-select, configuration and flush-pattern registers. Reads can reach those three, then the lock-up flags, two captured traffic bytes and the preconnect fault byte, which enter as read-only inputs. Reading the lock-up byte or a traffic byte raises a one-cycle acknowledge so that the status logic can clear or refresh it. Configuration bit 6 selects a reduced mode in which the channel-select register is the only register. A new channel selection reaches the channel-enable outputs only when the next stop arrives.

Top module: `chan_regbank`

## Requirements
- R1: A start sets the register index to 0. Each complete written byte and each read request then moves the index up by one.
- R2: In full mode (configuration bit 6 = 0), a write lands on index 0 (channel select), 1 (configuration) or 2 (flush pattern). After index 2 the index returns to 0, and a write to any index above 2 changes nothing.
- R3: In full mode a read returns, for index 0 to 6 in turn: channel select, configuration, flush pattern, lock-up flags, traffic byte A, traffic byte B, preconnect fault. After index 6 the index returns to 0. Read data appears on `rd_data` in the cycle after `rd_req`.
- R4: In reduced mode (configuration bit 6 = 1), every complete written byte goes to channel select, so the last byte of a transaction is the one kept. Every read returns channel select.
- R5: A write strobe with `wr_full` = 0 changes no register and does not move the index.
- R6: After reset, channel select is 0x00, configuration is 0x00 (full mode), the flush pattern is 0xFF and all channel enables are 0.
- R7: `ch_en` changes only in the cycle after `ev_stop`, and it then takes the channel-select value. Bit n enables channel n, and any set of channels may be enabled together.
- R8: In the cycle after a read of index 3, `ack_lock` is 1 for one cycle. In the cycle after a read of index 4 or 5, `ack_traffic` is 1 for one cycle.
- R9: Reads of indices 0, 1, 2 and 6, and all reads in reduced mode, raise neither acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_start | input | 1 | Transaction start event |
| ev_stop | input | 1 | Stop event; applies the channel selection |
| wr_valid | input | 1 | Write byte strobe |
| wr_full | input | 1 | 1 when the strobed byte has all eight bits |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read request for the byte at the index |
| lock_flags | input | 8 | Lock-up flags, read at index 3 |
| traffic_a | input | 8 | First captured traffic byte, index 4 |
| traffic_b | input | 8 | Second captured traffic byte, index 5 |
| precon_fault | input | 8 | Preconnect fault byte, index 6 |
| rd_data | output | 8 | Read data, registered |
| ch_en | output | 8 | Applied channel enables |
| cfg_q | output | 8 | Configuration register |
| flush_q | output | 8 | Flush pattern register |
| ack_lock | output | 1 | Pulse after the lock-up byte is read |
| ack_traffic | output | 1 | Pulse after a traffic byte is read |

## Verification
The hardest state to reach is the index wrap. The write side returns to 0 after index 2, but the read side only returns after index 6, and reduced mode cuts both down to index 0. The case most likely to hide a bug is a configuration write that turns reduced mode on in the middle of a transaction, so that the next byte goes to channel select and not to the flush pattern. The random transactions carry up to nine bytes so both wraps occur many times. Directed sequences then switch mode mid-transaction and strobe partial bytes between complete ones.

// File: rtl/chan_regbank_pkg.sv
package chan_regbank_pkg;
    localparam int DW        = 8;
    localparam int IW        = 3;
    localparam int WR_LAST   = 2;
    localparam int RD_LAST   = 6;
    localparam int BASIC_BIT = 6;

    typedef enum logic [IW-1:0] {
        IX_SEL    = 3'd0,
        IX_CFG    = 3'd1,
        IX_FLUSH  = 3'd2,
        IX_LOCK   = 3'd3,
        IX_TRAF_A = 3'd4,
        IX_TRAF_B = 3'd5,
        IX_PRECON = 3'd6
    } reg_ix_e;

    typedef struct packed {
        logic [DW-1:0] sel;
        logic [DW-1:0] cfg;
        logic [DW-1:0] flush;
    } rw_bank_t;

    typedef struct packed {
        logic [DW-1:0] lock;
        logic [DW-1:0] traf_a;
        logic [DW-1:0] traf_b;
        logic [DW-1:0] precon;
    } ro_bank_t;

    function automatic logic [IW-1:0] step_ix(input logic [IW-1:0] cur, input int last);
        return (int'(cur) >= last) ? '0 : cur + 1'b1;
    endfunction
endpackage

// File: rtl/rb_pointer.sv
module rb_pointer
    import chan_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          adv_wr,
    input  logic          adv_rd,
    input  logic          basic,
    output logic [IW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst || start)   ptr <= '0;
        else if (basic)     ptr <= '0;
        else if (adv_wr)    ptr <= step_ix(ptr, WR_LAST);
        else if (adv_rd)    ptr <= step_ix(ptr, RD_LAST);
    end

    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |=> ptr == '0);                                        // R1
    AST_WR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv_wr && !start && !basic && ptr == 3'(WR_LAST)) |=> ptr == '0); // R2
    AST_RD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv_rd && !adv_wr && !start && !basic && ptr == 3'(RD_LAST)) |=> ptr == '0); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv_wr && !adv_rd && !start && !basic) |=> $stable(ptr));  // R5
endmodule

// File: rtl/rb_regs.sv
module rb_regs
    import chan_regbank_pkg::*;
#(
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_ix,
    input  logic [W-1:0]  wr_data,
    input  logic          stop,
    output rw_bank_t      bank,
    output logic [W-1:0]  ch_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank.sel   <= '0;
            bank.cfg   <= '0;
            bank.flush <= '1;
        end else if (wr_en) begin
            case (wr_ix)
                IX_SEL:   bank.sel   <= wr_data;
                IX_CFG:   bank.cfg   <= wr_data;
                IX_FLUSH: bank.flush <= wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ch_en <= '0;
        else if (stop) ch_en <= bank.sel;
    end

    AST_CH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stop |=> $stable(ch_en));                                   // R7
    AST_RO_SAFE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_ix) > WR_LAST) |=> $stable(bank));         // R2
endmodule

// File: rtl/rb_readmux.sv
module rb_readmux
    import chan_regbank_pkg::*;
#(
    parameter int W = DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_ix,
    input  rw_bank_t      rw,
    input  ro_bank_t      ro,
    output logic [W-1:0]  rd_data,
    output logic          ack_lock,
    output logic          ack_traffic
);
    logic [W-1:0] sel_byte;

    always_comb begin
        case (rd_ix)
            IX_SEL:    sel_byte = rw.sel;
            IX_CFG:    sel_byte = rw.cfg;
            IX_FLUSH:  sel_byte = rw.flush;
            IX_LOCK:   sel_byte = ro.lock;
            IX_TRAF_A: sel_byte = ro.traf_a;
            IX_TRAF_B: sel_byte = ro.traf_b;
            IX_PRECON: sel_byte = ro.precon;
            default:   sel_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data     <= '0;
            ack_lock    <= 1'b0;
            ack_traffic <= 1'b0;
        end else begin
            if (rd_en) rd_data <= sel_byte;
            ack_lock    <= rd_en && rd_ix == IX_LOCK;
            ack_traffic <= rd_en && (rd_ix == IX_TRAF_A || rd_ix == IX_TRAF_B);
        end
    end

    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ack_lock, ack_traffic}));                          // R8
    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !ack_lock && !ack_traffic);                       // R9
endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
    import chan_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          wr_valid,
    input  logic          wr_full,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [DW-1:0] lock_flags,
    input  logic [DW-1:0] traffic_a,
    input  logic [DW-1:0] traffic_b,
    input  logic [DW-1:0] precon_fault,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ch_en,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] flush_q,
    output logic          ack_lock,
    output logic          ack_traffic
);
    logic          basic;
    logic          adv_wr;
    logic [IW-1:0] ptr;
    logic [IW-1:0] eff_ix;
    rw_bank_t      rw;
    ro_bank_t      ro;

    assign adv_wr = wr_valid && wr_full;
    assign basic  = rw.cfg[BASIC_BIT];
    assign eff_ix = basic ? IX_SEL : ptr;
    assign ro     = '{lock: lock_flags, traf_a: traffic_a, traf_b: traffic_b, precon: precon_fault};
    assign cfg_q   = rw.cfg;
    assign flush_q = rw.flush;

    rb_pointer u_ptr (
        .clk(clk), .rst(rst), .start(ev_start), .adv_wr(adv_wr),
        .adv_rd(rd_req), .basic(basic), .ptr(ptr)
    );

    rb_regs #(.W(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(adv_wr), .wr_ix(eff_ix),
        .wr_data(wr_data), .stop(ev_stop), .bank(rw), .ch_en(ch_en)
    );

    rb_readmux #(.W(DW)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_req), .rd_ix(eff_ix), .rw(rw), .ro(ro),
        .rd_data(rd_data), .ack_lock(ack_lock), .ack_traffic(ack_traffic)
    );

    AST_BASIC_SEL: assert property (@(posedge clk) disable iff (rst)
        (basic && rd_req) |=> !ack_lock && !ack_traffic);            // R4
    AST_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_full && !rd_req && !ev_start) |=> $stable(cfg_q) && $stable(flush_q)); // R5
endmodule

// File: tb/sim_chan_regbank.sv
module sim_chan_regbank;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_start = 0, ev_stop = 0, wr_valid = 0, wr_full = 0, rd_req = 0;
    logic [7:0] wr_data = 0, lock_flags = 0, traffic_a = 0, traffic_b = 0, precon_fault = 0;
    logic [7:0] rd_data, ch_en, cfg_q, flush_q;
    logic       ack_lock, ack_traffic;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_sel, m_cfg, m_flush, m_ch;
    logic [2:0] m_ix;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_regbank u0 (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .wr_valid(wr_valid), .wr_full(wr_full), .wr_data(wr_data), .rd_req(rd_req),
        .lock_flags(lock_flags), .traffic_a(traffic_a), .traffic_b(traffic_b),
        .precon_fault(precon_fault), .rd_data(rd_data), .ch_en(ch_en), .cfg_q(cfg_q),
        .flush_q(flush_q), .ack_lock(ack_lock), .ack_traffic(ack_traffic)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic bit m_basic();
        return m_cfg[6];
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] ix);
        case (ix)
            3'd0: return m_sel;
            3'd1: return m_cfg;
            3'd2: return m_flush;
            3'd3: return lock_flags;
            3'd4: return traffic_a;
            3'd5: return traffic_b;
            3'd6: return precon_fault;
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_sel = 8'h00; m_cfg = 8'h00; m_flush = 8'hFF; m_ch = 8'h00; m_ix = 0;
    endtask

    task automatic t_start();
        ev_start = 1; @(negedge clk); ev_start = 0;
        m_ix = 0;
    endtask

    task automatic t_stop();
        ev_stop = 1; @(negedge clk); ev_stop = 0;
        m_ch = m_sel;
        chk(ch_en == m_ch, "R7 stop applies", ch_en, m_ch);
    endtask

    task automatic t_write(input logic [7:0] d, input bit full);
        logic [2:0] ix;
        ix = m_basic() ? 3'd0 : m_ix;
        wr_valid = 1; wr_full = full; wr_data = d;
        @(negedge clk);
        wr_valid = 0; wr_full = 0;
        if (full) begin
            case (ix)
                3'd0: m_sel = d;
                3'd1: m_cfg = d;
                3'd2: m_flush = d;
                default: ;
            endcase
            m_ix = m_basic() ? 3'd0 : ((ix >= 3'd2) ? 3'd0 : ix + 3'd1);
        end
        chk(cfg_q == m_cfg, full ? "R2 cfg after write" : "R5 cfg after partial", cfg_q, m_cfg);
        chk(flush_q == m_flush, full ? "R2 flush after write" : "R5 flush after partial", flush_q, m_flush);
        chk(ch_en == m_ch, "R7 no change before stop", ch_en, m_ch);
    endtask

    task automatic t_read();
        logic [2:0] ix;
        logic [7:0] exp;
        ix = m_basic() ? 3'd0 : m_ix;
        exp = m_read(ix);
        rd_req = 1;
        @(negedge clk);
        rd_req = 0;
        chk(rd_data == exp, m_basic() ? "R4 read" : "R3 read", rd_data, exp);
        chk(ack_lock == (ix == 3'd3), (ix == 3'd3) ? "R8 lock ack" : "R9 no lock ack", {7'd0, ack_lock}, {7'd0, ix == 3'd3});
        chk(ack_traffic == (ix == 3'd4 || ix == 3'd5), (ix == 3'd4 || ix == 3'd5) ? "R8 traffic ack" : "R9 no traffic ack",
            {7'd0, ack_traffic}, {7'd0, ix == 3'd4 || ix == 3'd5});
        m_ix = m_basic() ? 3'd0 : ((ix >= 3'd6) ? 3'd0 : ix + 3'd1);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R6: reset values at the ports
        chk(ch_en == 8'h00, "R6 ch_en reset", ch_en, 8'h00);
        chk(cfg_q == 8'h00, "R6 cfg reset", cfg_q, 8'h00);
        chk(flush_q == 8'hFF, "R6 flush reset", flush_q, 8'hFF);
        lock_flags = 8'h81; traffic_a = 8'hA4; traffic_b = 8'h5B; precon_fault = 8'h3C;
        t_start(); repeat (3) t_read(); t_stop(); // R6 sel reads 00

        // R2: write wrap back to channel select
        t_start();
        t_write(8'h0F, 1); t_write(8'h12, 1); t_write(8'h77, 1); t_write(8'hF0, 1);
        chk(ch_en == 8'h00, "R7 held until stop", ch_en, 8'h00);
        t_stop();
        // R3/R8/R9: read all seven plus wrap
        t_start(); repeat (9) t_read(); t_stop();
        // R1: restart mid-sequence returns to index 0
        t_start(); t_read(); t_read(); t_start(); t_read(); t_stop();
        // R5: partial bytes interleaved
        t_start(); t_write(8'hAA, 0); t_write(8'h01, 1); t_write(8'hBB, 0); t_write(8'h22, 1); t_stop();
        t_start(); repeat (3) t_read(); t_stop();

        // random transactions in full mode
        for (int t = 0; t < 400; t++) begin
            int nb;
            lock_flags = 8'($urandom); traffic_a = 8'($urandom);
            traffic_b = 8'($urandom); precon_fault = 8'($urandom);
            nb = 1 + ($urandom % 9);
            t_start();
            if ($urandom % 2) begin
                for (int b = 0; b < nb; b++) begin
                    logic [7:0] d;
                    d = 8'($urandom);
                    if (!m_basic() && m_ix == 3'd1) d[6] = 1'b0;
                    t_write(d, ($urandom % 5) != 0);
                end
            end else begin
                for (int b = 0; b < nb; b++) t_read();
            end
            t_stop();
        end

        // R4: reduced mode entered mid-transaction
        t_start();
        t_write(8'h03, 1); t_write(8'h40, 1);
        t_write(8'h11, 1); t_write(8'h22, 1); t_write(8'h5A, 1);
        chk(flush_q == m_flush, "R4 flush untouched", flush_q, m_flush);
        t_stop();
        chk(ch_en == 8'h5A, "R4 last byte kept", ch_en, 8'h5A);
        t_start(); repeat (5) t_read(); t_stop();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule